// File: doc/BRIEF.md
# Write-Once Watchdog Timer

This block is a watchdog timer that software reaches through a simple 32-bit register port with byte addresses. One control word sets the reload count, the enable, a choice between a reset request and an interrupt on expiry, and an optional clock divider. The control word can be written only once after power-on. That single write decides for good whether the watchdog runs and how it behaves.

Once the watchdog is running, a 16-bit down-counter steps toward zero, either once per clock or once per divided tick. To restart it, software writes two fixed key values to the service register, in order. When the counter reaches zero, the block raises an interrupt or a reset request, depending on the locked mode. In interrupt mode the interrupt stays high until a valid service sequence. In reset mode the reset request is a pulse of fixed length. The bus fabric, the reset controller and the interrupt controller that consume these outputs sit outside the block.

Top module: `wdt_sentinel`

## Requirements
- R1: After reset, the control word (byte offset 0x4) reads 0xFFFF0000, the count word (offset 0x8) reads 0x0000FFFF, and `irq` and `rst_req` are low.
- R2: The first write to offset 0x4 after reset stores the reload count from bits 31:16, the enable from bit 2, the mode select from bit 1 and the divider enable from bit 0. Bits 15:3 read back as zero. Every later write to 0x4 is ignored, and reads keep returning the stored value.
- R3: If the first control write has bit 2 clear, the watchdog stays stopped for good. The count keeps its reset value, the outputs stay low, and neither a later control write nor a service sequence starts it.
- R4: A control write with bit 2 set loads the count with the reload value at that clock edge. With bit 0 clear, the count is then T−k, k cycles later, until it holds at zero.
- R5: With bit 0 set, the count steps down once every 2^DIV_LOG2 clocks. The first step comes 2^DIV_LOG2 cycles after the load.
- R6: Writing 0x556C and then 0xAA39 to the service register reloads a running counter to the reload value and restarts the divider. The service register is offset 0xE, and its data is taken from `wdata[15:0]`. Writes to other offsets between the two key writes do not break the sequence.
- R7: A service write of any value other than 0xAA39 right after 0x556C, or 0xAA39 with no 0x556C before it, reloads nothing and returns the sequence to idle.
- R8: With bit 1 clear, `irq` rises one cycle after the count reaches zero and stays high until a valid service sequence clears it at the edge of the second key write.
- R9: With bit 1 set, `rst_req` is high for exactly RST_PULSE cycles, starting one cycle after the count reaches zero. `irq` never rises in this mode.
- R10: A reload value of zero expires one cycle after the enabling write.
- R11: Writes to offset 0x8 have no effect, so the count keeps its course.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Expiry interrupt, held until serviced |
| rst_req | output | 1 | Expiry reset request pulse |

## Verification
The bench builds the block with DIV_LOG2 = 3 and RST_PULSE = 5. An 8-clock divided tick and a short reset pulse let it sweep every cycle, from the enabling write through expiry and past the end of the pulse. It runs this sweep for several reload values, including zero, in both divider settings and both expiry modes. It compares count, `irq` and `rst_req` each cycle against values worked out from the reload value and the step length. The same small setting keeps the key-sequence cases short: valid, broken, lone second key and repeated first key. It also keeps short the lock cases, where the enable is left clear or the control word is rewritten.

// File: rtl/wdt_sentinel_pkg.sv
package wdt_sentinel_pkg;

    localparam int BUS_W = 32;
    localparam int CNT_W = 16;
    localparam int SVC_W = 16;

    // Byte offsets that software decodes
    localparam int OFS_CTRL  = 4;
    localparam int OFS_COUNT = 8;
    localparam int OFS_SVC   = 14;

    // Ordered service keys
    localparam logic [SVC_W-1:0] KEY_FIRST  = 16'h556C;
    localparam logic [SVC_W-1:0] KEY_SECOND = 16'hAA39;

    // Control word layout, MSB first
    typedef struct packed {
        logic [CNT_W-1:0] reload;   // 31:16
        logic [12:0]      rsvd;     // 15:3
        logic             arm;      // 2
        logic             rst_sel;  // 1
        logic             prediv;   // 0
    } ctrl_t;

    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_t;

    localparam ctrl_t CTRL_RESET = '{reload: 16'hFFFF, default: '0};

    function automatic ctrl_t ctrl_from_word(logic [BUS_W-1:0] w);
        ctrl_t c;
        c      = ctrl_t'(w);
        c.rsvd = '0;
        return c;
    endfunction

endpackage

// File: rtl/wdt_sentinel_regs.sv
module wdt_sentinel_regs
    import wdt_sentinel_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  count,
    output ctrl_t             ctrl_q,
    output logic              locked,
    output logic              armed,
    output logic              ctrl_load,
    output logic [CNT_W-1:0]  new_reload,
    output logic              new_arm,
    output logic              svc_wr,
    output logic [SVC_W-1:0]  svc_data,
    output logic [BUS_W-1:0]  rdata
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_SVC   = ADDR_W'(OFS_SVC);

    ctrl_t ctrl_wr;

    assign ctrl_wr    = ctrl_from_word(wdata);
    assign ctrl_load  = wr_en && (addr == A_CTRL) && !locked;
    assign new_reload = ctrl_wr.reload;
    assign new_arm    = ctrl_wr.arm;
    assign svc_wr     = wr_en && (addr == A_SVC);
    assign svc_data   = wdata[SVC_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            locked <= 1'b0;
            armed  <= 1'b0;
        end else if (ctrl_load) begin
            ctrl_q <= ctrl_wr;
            locked <= 1'b1;
            armed  <= ctrl_wr.arm;
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = ctrl_q;
            A_COUNT: rdata = {{(BUS_W-CNT_W){1'b0}}, count};
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_sentinel_keyseq.sv
module wdt_sentinel_keyseq
    import wdt_sentinel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             svc_wr,
    input  logic [SVC_W-1:0] svc_data,
    output logic             key_ok
);
    seq_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        key_ok  = 1'b0;
        if (svc_wr) begin
            case (state_q)
                SEQ_IDLE:  state_d = (svc_data == KEY_FIRST) ? SEQ_ARMED : SEQ_IDLE;
                SEQ_ARMED: begin
                    key_ok  = (svc_data == KEY_SECOND);
                    state_d = SEQ_IDLE;
                end
                default:   state_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/wdt_sentinel_ticker.sv
module wdt_sentinel_ticker #(
    parameter int DIV_LOG2 = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    input  logic prediv,
    output logic tick
);
    logic [DIV_LOG2-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || restart) phase_q <= '0;
        else if (run)       phase_q <= phase_q + 1'b1;
    end

    assign tick = run && (!prediv || (&phase_q));

endmodule

// File: rtl/wdt_sentinel_countdown.sv
module wdt_sentinel_countdown
    import wdt_sentinel_pkg::*;
#(
    parameter int RST_PULSE = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             active,
    input  logic             rst_sel,
    output logic [CNT_W-1:0] count_q,
    output logic             irq,
    output logic             rst_req
);
    localparam int PW = $clog2(RST_PULSE + 1);

    logic          expired_q;
    logic          fire;
    logic [PW-1:0] pulse_q;

    assign fire = active && (count_q == '0) && !expired_q && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '1;
            expired_q <= 1'b0;
            irq       <= 1'b0;
        end else if (load) begin
            count_q   <= load_val;
            expired_q <= 1'b0;
            irq       <= 1'b0;
        end else begin
            if (tick && (count_q != '0)) count_q <= count_q - 1'b1;
            if (fire) begin
                expired_q <= 1'b1;
                if (!rst_sel) irq <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                   pulse_q <= '0;
        else if (fire && rst_sel)  pulse_q <= PW'(RST_PULSE);
        else if (pulse_q != '0)    pulse_q <= pulse_q - 1'b1;
    end

    assign rst_req = (pulse_q != '0);

endmodule

// File: rtl/wdt_sentinel.sv
module wdt_sentinel
    import wdt_sentinel_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DIV_LOG2  = 16,
    parameter int RST_PULSE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq,
    output logic              rst_req
);
    ctrl_t            ctrl_q;
    logic             locked, armed, ctrl_load, new_arm;
    logic [CNT_W-1:0] new_reload, count_q, load_val;
    logic             svc_wr, key_ok, svc_reload, load, tick;
    logic [SVC_W-1:0] svc_data;

    wdt_sentinel_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .count(count_q), .ctrl_q(ctrl_q), .locked(locked), .armed(armed),
        .ctrl_load(ctrl_load), .new_reload(new_reload), .new_arm(new_arm),
        .svc_wr(svc_wr), .svc_data(svc_data), .rdata(rdata)
    );

    wdt_sentinel_keyseq u_keyseq (
        .clk(clk), .rst(rst), .svc_wr(svc_wr), .svc_data(svc_data), .key_ok(key_ok)
    );

    assign svc_reload = key_ok && armed;
    assign load       = (ctrl_load && new_arm) || svc_reload;
    assign load_val   = ctrl_load ? new_reload : ctrl_q.reload;

    wdt_sentinel_ticker #(.DIV_LOG2(DIV_LOG2)) u_ticker (
        .clk(clk), .rst(rst), .restart(load), .run(armed),
        .prediv(ctrl_q.prediv), .tick(tick)
    );

    wdt_sentinel_countdown #(.RST_PULSE(RST_PULSE)) u_countdown (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val), .tick(tick),
        .active(armed), .rst_sel(ctrl_q.rst_sel), .count_q(count_q),
        .irq(irq), .rst_req(rst_req)
    );

endmodule

// File: rtl/wdt_sentinel_chk.sv
module wdt_sentinel_chk (
    input logic        clk,
    input logic        rst,
    input logic        irq,
    input logic        rst_req,
    input logic [15:0] count_q,
    input logic [31:0] ctrl_word,
    input logic        locked,
    input logic        active,
    input logic        ctrl_load,
    input logic        svc_reload
);
    // R2: a locked control word never changes and stays locked
    a_r2_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
        locked |=> (locked && $stable(ctrl_word)));

    // R3: a stopped watchdog's count moves only through the enabling write
    a_r3_idle_count: assert property (@(posedge clk) disable iff (rst)
        (!active && !ctrl_load) |=> $stable(count_q));

    // R4: without a reload the running count holds or drops by one
    a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
        (active && !svc_reload) |=>
            ((count_q == $past(count_q)) || (count_q == $past(count_q) - 16'd1)));

    // R8: the interrupt only rises at zero and holds until serviced
    a_r8_irq_at_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (count_q == 16'd0));
    a_r8_irq_holds: assert property (@(posedge clk) disable iff (rst)
        (irq && !svc_reload) |=> irq);

    // R9: the two expiry outputs are never high together
    a_r9_one_mode: assert property (@(posedge clk) disable iff (rst)
        !(irq && rst_req));

endmodule

bind wdt_sentinel wdt_sentinel_chk i_chk (
    .clk(clk), .rst(rst), .irq(irq), .rst_req(rst_req), .count_q(count_q),
    .ctrl_word(ctrl_q), .locked(locked), .active(armed),
    .ctrl_load(ctrl_load), .svc_reload(svc_reload)
);

// File: tb/test_wdt_sentinel.sv
`timescale 1ns/1ps
module test_wdt_sentinel;
    localparam int DIVL   = 3;
    localparam int PULSE  = 5;
    localparam int AW     = 4;
    localparam int STEP_P = 1 << DIVL;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq, rst_req;

    int vecs = 0;
    int bad  = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdt_sentinel #(.ADDR_W(AW), .DIV_LOG2(DIVL), .RST_PULSE(PULSE)) i_wdt_sentinel (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic chk_count(input string tag, input int exp);
        logic [31:0] v;
        rd(4'h8, v);
        chk(tag, v, 32'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vecs++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int tv[5] = '{0, 1, 2, 5, 9};

        // R1 reset state, then R2/R3 lock with the enable left clear
        do_reset();
        rd(4'h4, v); chk("R1 ctrl reset", v, 32'hFFFF_0000);
        chk_count("R1 count reset", 16'hFFFF);
        chk("R1 irq reset", {31'd0, irq}, 0);
        chk("R1 rst_req reset", {31'd0, rst_req}, 0);
        wr(4'h4, 32'h1234_FFFA);
        rd(4'h4, v); chk("R2 ctrl readback", v, 32'h1234_0002);
        repeat (10) @(negedge clk);
        chk_count("R3 count frozen", 16'hFFFF);
        chk("R3 irq low", {31'd0, irq}, 0);
        chk("R3 rst_req low", {31'd0, rst_req}, 0);
        wr(4'h4, 32'h0002_0007);
        rd(4'h4, v); chk("R2 ctrl ignores rewrite", v, 32'h1234_0002);
        wr(4'hE, 32'h556C); wr(4'hE, 32'hAA39);
        repeat (4) @(negedge clk);
        chk_count("R3 service has no effect", 16'hFFFF);
        chk("R3 irq still low", {31'd0, irq}, 0);

        // R4 R5 R8 R9 R10 sweep: every cycle from enable to past expiry
        for (int ti = 0; ti < 5; ti++) begin
            for (int p = 0; p < 2; p++) begin
                for (int m = 0; m < 2; m++) begin
                    int t = tv[ti];
                    int s = (p != 0) ? STEP_P : 1;
                    int e = t * s;
                    do_reset();
                    wr(4'h4, {16'(t), 13'd0, 1'b1, m[0], p[0]});
                    for (int k = 0; k <= e + PULSE + 3; k++) begin
                        int ec = t - (k / s);
                        if (ec < 0) ec = 0;
                        chk_count((t == 0) ? "R10 count" : ((p != 0) ? "R5 count" : "R4 count"), ec);
                        chk((m == 0) ? ((t == 0) ? "R10 irq" : "R8 irq") : "R9 irq stays low",
                            {31'd0, irq}, {31'd0, (m == 0) && (k >= e + 1)});
                        chk((t == 0) ? "R10 rst_req" : "R9 rst_req", {31'd0, rst_req},
                            {31'd0, (m == 1) && (k >= e + 1) && (k <= e + PULSE)});
                        @(negedge clk);
                    end
                end
            end
        end

        // R8/R6 interrupt cleared by a valid sequence, R11 write to count
        do_reset();
        wr(4'h4, {16'd4, 13'd0, 3'b100});
        repeat (6) @(negedge clk);
        chk("R8 irq after expiry", {31'd0, irq}, 1);
        wr(4'hE, 32'h556C);
        chk("R8 irq held mid sequence", {31'd0, irq}, 1);
        wr(4'h8, 32'h0000_0003);
        chk_count("R11 count write ignored", 0);
        wr(4'hE, 32'hAA39);
        chk_count("R6 reload after interleaved write", 4);
        chk("R8 irq cleared by service", {31'd0, irq}, 0);
        @(negedge clk);
        chk_count("R6 count resumes", 3);

        // R7 broken sequences, R6 valid one, R11, R2 on a running timer
        do_reset();
        wr(4'h4, {16'd40, 13'd0, 3'b100});
        chk_count("R4 load on enable", 40);
        wr(4'hE, 32'hAA39);
        chk_count("R7 lone second key", 39);
        wr(4'hE, 32'h556C); wr(4'hE, 32'h1234); wr(4'hE, 32'hAA39);
        chk_count("R7 wrong value after first key", 36);
        wr(4'hE, 32'h556C); wr(4'hE, 32'h556C); wr(4'hE, 32'hAA39);
        chk_count("R7 repeated first key", 33);
        wr(4'hE, 32'h556C); wr(4'hE, 32'hAA39);
        chk_count("R6 valid sequence reloads", 40);
        wr(4'h8, 32'h0000_FFFF);
        chk_count("R11 count write ignored", 39);
        wr(4'h4, 32'h0001_0003);
        rd(4'h4, v); chk("R2 ctrl locked while running", v, 32'h0028_0004);
        chk_count("R2 rewrite does not reload", 38);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule